// File: doc/BRIEF.md
# Interrupt Distributor Register Slave

This block is the register-facing front of a simplified interrupt distributor. It has a single security state and one interrupt group. A host reaches it over a small valid/ready bus with a 32-bit data path and word-aligned offsets. Through this bus the host can switch the group on or off, set or clear the enable and pending bits of the shared interrupts, and store a byte-wide priority for each shared interrupt. It can also read fixed capability and identification words.

The pending bits leave the block as a vector, one bit per interrupt ID. The first 32 interrupt IDs are private to the processors and are never held here. The block does no arbitration: priorities are stored and read back, but nothing acts on them. Several register windows exist only so that software finds them. These windows return all ones or all zeros and ignore writes, as does any offset that is not mapped.

Top module: `irq_dist_regs`

## Requirements
- R1: A request is accepted when `req_valid_i` and `req_ready_o` are both high. Its response appears with `rsp_valid_o` on the following cycle. While `rsp_ready_i` is low, the response and its data are held and `req_ready_o` is low.
- R2: Control word at offset 0x000:
  - bit 1 is the group enable; it is writable and mirrored on `grp1_en_o`;
  - bits 4 and 6 always read 1;
  - every other bit reads 0.
  After reset the word reads 0x50.
- R3: Bit 0 of the control word is the other-group enable. It always reads 0. A write with bit 0 set raises `g0_warn_o` for exactly the cycle in which that write's response is valid.
- R4: The capability word at 0x004 reads as follows and ignores writes:
  - bits [4:0] hold min(NUM_IRQ,1024)/32 − 1;
  - bits [23:19] hold 9;
  - bits 16 and 17 read 0.
  With NUM_IRQ=64 this is 0x00480001.
- R5: The identity word at 0x008 holds PRODUCT_ID in bits [31:24] and IMPL_ID in bits [11:0] (0x4B00043B by default). Offset 0xFE8 reads 0x3B. Every other word in 0xFD0–0xFFC reads 0.
- R6: The enable-set window is at 0x100 and the enable-clear window is at 0x180. Word k covers IDs 32k..32k+31, with bit n for ID 32k+n. A write to the set window ORs the data into the stored bits. A write to the clear window clears each bit where the data is 1. A read of either window returns the stored bits.
- R7: The pending-set window (0x200) and pending-clear window (0x280) behave the same way as the enable windows, and `pend_o[i]` shows the pending bit of ID i.
- R8: Word 0 of each set/clear window (IDs 0–31) reads 0 and ignores writes, and `pend_o[31:0]` stays 0.
- R9: The priority window is at 0x400, with byte b of word w belonging to ID 4w+b. Words 0–7 (IDs 0–31) read 0 and ignore writes. Words for IDs 32..NUM_IRQ−1 are read/write storage that resets to 0.
- R10: The group window 0x080–0x0FC reads 0xFFFFFFFF and ignores writes.
- R11: The following ranges read 0 and ignore writes:
  - the active windows 0x300–0x3FC;
  - the target window 0x800–0xBFF;
  - 0xC00–0xCFC, 0xD00–0xDFC and 0xE00–0xEFC;
  - any unmapped offset.
  Every such access still completes.
- R12: Set/clear and priority words that cover IDs at or above NUM_IRQ read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset, word aligned |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumer ready |
| rsp_rdata_o | output | 32 | Read data (0 for writes) |
| grp1_en_o | output | 1 | Group enable state |
| g0_warn_o | output | 1 | Pulse: write tried to set the other-group enable |
| pend_o | output | NUM_IRQ | Pending bit per interrupt ID |

## Verification
A wrong bit in a stored enable or pending array shows up on the next read of the matching set or clear word. For the pending array, it also shows up at once on `pend_o`, in the cycle right after the write edge. A decode that reaches the wrong word is exposed in two ways. First, writing to private, out-of-range and read-only windows and then reading the neighbouring live words shows that the live words kept their values. Second, those read-only words keep their fixed values after the writes. A control-bit error shows in the next control read and on `grp1_en_o` or `g0_warn_o` one cycle after the write. The stall test shows whether the response is held while the consumer is not ready.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

  typedef enum logic [3:0] {
    REG_ZERO, REG_CTRL, REG_TYPE, REG_IDENT, REG_ONES,
    REG_SETEN, REG_CLREN, REG_SETPEND, REG_CLRPEND, REG_PRIO, REG_IDSP
  } reg_e;

  localparam int CTRL_G0_BIT  = 0;
  localparam int CTRL_G1_BIT  = 1;
  localparam int CTRL_ARE_BIT = 4;
  localparam int CTRL_DS_BIT  = 6;

  localparam int PRIV_IRQS    = 32;
  localparam int IDBITS_FIELD = 9;
  localparam logic [31:0] IDSP_VAL = 32'h0000_003B;

  function automatic reg_e decode(input logic [11:0] a);
    reg_e r;
    r = REG_ZERO;
    if (a[11:2] == 10'd0)      r = REG_CTRL;
    else if (a[11:2] == 10'd1) r = REG_TYPE;
    else if (a[11:2] == 10'd2) r = REG_IDENT;
    else if (a[11:7] == 5'h01) r = REG_ONES;
    else if (a[11:7] == 5'h02) r = REG_SETEN;
    else if (a[11:7] == 5'h03) r = REG_CLREN;
    else if (a[11:7] == 5'h04) r = REG_SETPEND;
    else if (a[11:7] == 5'h05) r = REG_CLRPEND;
    else if (a[11:10] == 2'b01) r = REG_PRIO;
    else if (a == 12'hFE8)     r = REG_IDSP;
    return r;
  endfunction

endpackage

// File: rtl/dist_bitarray.sv
module dist_bitarray #(
  parameter int NUM_IRQ = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_we_i,
  input  logic                 clr_we_i,
  input  logic [4:0]           widx_i,
  input  logic [31:0]          wdata_i,
  output logic [NUM_IRQ-33:0]  bits_o,
  output logic [31:0]          rdata_o
);
  localparam int NWORD = NUM_IRQ / 32;
  localparam int NSPI  = NUM_IRQ - 32;

  logic [NSPI-1:0] bits_q;

  // word 0 (private IDs) has no storage
  for (genvar k = 1; k < NWORD; k++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bits_q[(k-1)*32 +: 32] <= '0;
      end else if (widx_i == 5'(k)) begin
        if (set_we_i)      bits_q[(k-1)*32 +: 32] <= bits_q[(k-1)*32 +: 32] | wdata_i;
        else if (clr_we_i) bits_q[(k-1)*32 +: 32] <= bits_q[(k-1)*32 +: 32] & ~wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 1; k < NWORD; k++)
      if (widx_i == 5'(k)) rdata_o = bits_q[(k-1)*32 +: 32];
  end

  assign bits_o = bits_q;

  // R6, R7
  set_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i && widx_i == 5'd1 |=> (bits_q[31:0] & $past(wdata_i)) == $past(wdata_i));
  // R6, R7
  clr_and_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i && widx_i == 5'd1 |=> (bits_q[31:0] & $past(wdata_i)) == 32'd0);
  // R6, R7
  bits_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_we_i && !clr_we_i |=> $stable(bits_q));

endmodule

// File: rtl/dist_prio_bank.sv
module dist_prio_bank #(
  parameter int NUM_IRQ = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [7:0]  widx_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  localparam int PWORD = NUM_IRQ / 4;
  localparam int PRIV  = 8;
  localparam int NST   = PWORD - PRIV;

  logic [31:0] prio_q [NST];

  for (genvar w = 0; w < NST; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                prio_q[w] <= '0;
      else if (we_i && widx_i == 8'(w + PRIV))    prio_q[w] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NST; w++)
      if (widx_i == 8'(w + PRIV)) rdata_o = prio_q[w];
  end

  // R9
  prio_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && widx_i == 8'(PRIV) |=> prio_q[0] == $past(wdata_i));
  // R9
  prio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(prio_q[0]));

endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import irq_dist_pkg::*;
#(
  parameter int          NUM_IRQ    = 64,
  parameter logic [7:0]  PRODUCT_ID = 8'h4B,
  parameter logic [11:0] IMPL_ID    = 12'h43B
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic [11:0]        req_addr_i,
  input  logic [31:0]        req_wdata_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [31:0]        rsp_rdata_o,
  output logic               grp1_en_o,
  output logic               g0_warn_o,
  output logic [NUM_IRQ-1:0] pend_o
);
  localparam int CAP_IRQ   = (NUM_IRQ > 1024) ? 1024 : NUM_IRQ;
  localparam int LINES     = CAP_IRQ / 32 - 1;
  localparam logic [31:0] TYPE_VAL  = 32'(LINES) | (32'(IDBITS_FIELD) << 19);
  localparam logic [31:0] IDENT_VAL = {PRODUCT_ID, 12'd0, IMPL_ID};

  logic        acc, wr_acc;
  reg_e        region;
  logic        grp1_q, warn_q, rsp_valid_q;
  logic [31:0] rdata_q, rd_data, en_rdata, pend_rdata, prio_rdata;
  logic [NUM_IRQ-33:0] en_bits, pend_bits;

  assign req_ready_o = !rsp_valid_q || rsp_ready_i;
  assign acc         = req_valid_i && req_ready_o;
  assign wr_acc      = acc && req_write_i;
  assign region      = decode(req_addr_i);

  dist_bitarray #(.NUM_IRQ(NUM_IRQ)) u_enable (
    .clk_i, .rst_ni,
    .set_we_i (wr_acc && region == REG_SETEN),
    .clr_we_i (wr_acc && region == REG_CLREN),
    .widx_i   (req_addr_i[6:2]),
    .wdata_i  (req_wdata_i),
    .bits_o   (en_bits),
    .rdata_o  (en_rdata)
  );

  dist_bitarray #(.NUM_IRQ(NUM_IRQ)) u_pending (
    .clk_i, .rst_ni,
    .set_we_i (wr_acc && region == REG_SETPEND),
    .clr_we_i (wr_acc && region == REG_CLRPEND),
    .widx_i   (req_addr_i[6:2]),
    .wdata_i  (req_wdata_i),
    .bits_o   (pend_bits),
    .rdata_o  (pend_rdata)
  );

  dist_prio_bank #(.NUM_IRQ(NUM_IRQ)) u_prio (
    .clk_i, .rst_ni,
    .we_i    (wr_acc && region == REG_PRIO),
    .widx_i  (req_addr_i[9:2]),
    .wdata_i (req_wdata_i),
    .rdata_o (prio_rdata)
  );

  always_comb begin
    rd_data = '0;
    unique case (region)
      REG_CTRL: begin
        rd_data[CTRL_G1_BIT]  = grp1_q;
        rd_data[CTRL_ARE_BIT] = 1'b1;
        rd_data[CTRL_DS_BIT]  = 1'b1;
      end
      REG_TYPE:                rd_data = TYPE_VAL;
      REG_IDENT:               rd_data = IDENT_VAL;
      REG_IDSP:                rd_data = IDSP_VAL;
      REG_ONES:                rd_data = '1;
      REG_SETEN, REG_CLREN:    rd_data = en_rdata;
      REG_SETPEND, REG_CLRPEND: rd_data = pend_rdata;
      REG_PRIO:                rd_data = prio_rdata;
      default:                 rd_data = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp1_q      <= 1'b0;
      warn_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      warn_q <= wr_acc && region == REG_CTRL && req_wdata_i[CTRL_G0_BIT];
      if (wr_acc && region == REG_CTRL) grp1_q <= req_wdata_i[CTRL_G1_BIT];
      if (acc) begin
        rsp_valid_q <= 1'b1;
        rdata_q     <= req_write_i ? 32'd0 : rd_data;
      end else if (rsp_ready_i) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rdata_q;
  assign grp1_en_o   = grp1_q;
  assign g0_warn_o   = warn_q;
  assign pend_o      = {pend_bits, 32'd0};

  // R1
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_rdata_o));
  // R1
  rsp_after_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> rsp_valid_o);
  // R2
  grp1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_acc && region == REG_CTRL) |=> $stable(grp1_en_o));
  // R3
  warn_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g0_warn_o |-> rsp_valid_o && $past(req_write_i) && $past(req_wdata_i[CTRL_G0_BIT]));

endmodule

// File: tb/irq_dist_regs_tb.sv
module irq_dist_regs_tb;
  localparam int NUM_IRQ = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, grp1_en, g0_warn;
  logic [31:0] rsp_rdata;
  logic [NUM_IRQ-1:0] pend;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_dist_regs #(.NUM_IRQ(NUM_IRQ)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .grp1_en_o(grp1_en), .g0_warn_o(g0_warn), .pend_o(pend)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(req, {63'd0, rsp_valid}, 64'd1);
    check(req, {32'd0, d}, {32'd0, exp});
  endtask

  task automatic t_reset();
    rd_chk("R2 ctrl reset", 12'h000, 32'h50);
    check("R2 grp1 reset", {63'd0, grp1_en}, 64'd0);
    check("R7 pend reset", pend, 64'd0);
  endtask

  task automatic t_ctrl();
    bus_write(12'h000, 32'h2);
    check("R2 grp1_en after set", {63'd0, grp1_en}, 64'd1);
    rd_chk("R2 ctrl grp1 set", 12'h000, 32'h52);
    bus_write(12'h000, 32'hFFFF_FFFE);
    rd_chk("R2 ctrl forced bits", 12'h000, 32'h52);
    bus_write(12'h000, 32'h0);
    rd_chk("R2 ctrl cleared", 12'h000, 32'h50);
    check("R2 grp1_en cleared", {63'd0, grp1_en}, 64'd0);
  endtask

  task automatic t_warn();
    bus_write(12'h000, 32'h3);
    check("R3 warn pulse", {63'd0, g0_warn}, 64'd1);
    @(negedge clk);
    check("R3 warn one cycle", {63'd0, g0_warn}, 64'd0);
    rd_chk("R3 g0 bit reads 0", 12'h000, 32'h52);
    bus_write(12'h000, 32'h2);
    check("R3 no warn without bit0", {63'd0, g0_warn}, 64'd0);
    bus_write(12'h000, 32'h0);
  endtask

  task automatic t_ids();
    rd_chk("R4 type", 12'h004, 32'h0048_0001);
    bus_write(12'h004, 32'hFFFF_FFFF);
    rd_chk("R4 type write ignored", 12'h004, 32'h0048_0001);
    rd_chk("R5 ident", 12'h008, 32'h4B00_043B);
    rd_chk("R5 id word 0x3B", 12'hFE8, 32'h3B);
    rd_chk("R5 id other", 12'hFE0, 32'h0);
    rd_chk("R5 id first", 12'hFD0, 32'h0);
  endtask

  task automatic t_enable();
    bus_write(12'h104, 32'h0000_00F0);
    bus_write(12'h104, 32'h0F00_0000);
    rd_chk("R6 set ORs", 12'h104, 32'h0F00_00F0);
    rd_chk("R6 clear reads stored", 12'h184, 32'h0F00_00F0);
    bus_write(12'h184, 32'h0000_0030);
    rd_chk("R6 clear ones only", 12'h104, 32'h0F00_00C0);
    check("R6 enable not on pend", pend, 64'd0);
  endtask

  task automatic t_pend();
    bus_write(12'h204, 32'h8000_0001);
    check("R7 pend_o set", pend, {32'h8000_0001, 32'd0});
    bus_write(12'h284, 32'h0000_0001);
    check("R7 pend_o clear", pend, {32'h8000_0000, 32'd0});
    rd_chk("R7 pend readback", 12'h284, 32'h8000_0000);
  endtask

  task automatic t_private();
    bus_write(12'h100, 32'hFFFF_FFFF);
    bus_write(12'h200, 32'hFFFF_FFFF);
    rd_chk("R8 private enable", 12'h100, 32'h0);
    rd_chk("R8 private pending", 12'h200, 32'h0);
    rd_chk("R8 private clear word", 12'h180, 32'h0);
    check("R8 pend_o private", pend, {32'h8000_0000, 32'd0});
    rd_chk("R8 shared enable untouched", 12'h104, 32'h0F00_00C0);
  endtask

  task automatic t_prio();
    bus_write(12'h420, 32'hA1B2_C3D4);
    bus_write(12'h43C, 32'h1122_3344);
    rd_chk("R9 prio first shared", 12'h420, 32'hA1B2_C3D4);
    rd_chk("R9 prio last", 12'h43C, 32'h1122_3344);
    rd_chk("R9 prio reset value", 12'h424, 32'h0);
    bus_write(12'h400, 32'hFFFF_FFFF);
    bus_write(12'h41C, 32'hFFFF_FFFF);
    rd_chk("R9 prio private 0", 12'h400, 32'h0);
    rd_chk("R9 prio private 7", 12'h41C, 32'h0);
    rd_chk("R9 prio neighbour kept", 12'h420, 32'hA1B2_C3D4);
  endtask

  task automatic t_range();
    bus_write(12'h108, 32'hFFFF_FFFF);
    bus_write(12'h208, 32'hFFFF_FFFF);
    rd_chk("R12 enable beyond", 12'h108, 32'h0);
    rd_chk("R12 pending beyond", 12'h288, 32'h0);
    check("R12 pend_o unchanged", pend, {32'h8000_0000, 32'd0});
    bus_write(12'h440, 32'hFFFF_FFFF);
    rd_chk("R12 prio beyond", 12'h440, 32'h0);
    rd_chk("R12 prio last kept", 12'h43C, 32'h1122_3344);
  endtask

  task automatic t_ones();
    rd_chk("R10 group first", 12'h080, 32'hFFFF_FFFF);
    bus_write(12'h0FC, 32'h0);
    rd_chk("R10 group last", 12'h0FC, 32'hFFFF_FFFF);
  endtask

  task automatic t_raz();
    bus_write(12'h300, 32'hFFFF_FFFF);
    rd_chk("R11 active", 12'h300, 32'h0);
    bus_write(12'h800, 32'hFFFF_FFFF);
    rd_chk("R11 target", 12'h800, 32'h0);
    rd_chk("R11 c00", 12'hC00, 32'h0);
    rd_chk("R11 d00", 12'hD00, 32'h0);
    bus_write(12'hE00, 32'hFFFF_FFFF);
    rd_chk("R11 e00", 12'hE00, 32'h0);
    rd_chk("R11 unmapped 00c", 12'h00C, 32'h0);
    rd_chk("R11 unmapped f00", 12'hF00, 32'h0);
    rd_chk("R11 ctrl untouched", 12'h000, 32'h50);
  endtask

  task automatic t_stall();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h004;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 valid after accept", {63'd0, rsp_valid}, 64'd1);
    check("R1 ready low while stalled", {63'd0, req_ready}, 64'd0);
    @(negedge clk);
    @(negedge clk);
    check("R1 valid held", {63'd0, rsp_valid}, 64'd1);
    check("R1 data held", {32'd0, rsp_rdata}, 64'h0048_0001);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R1 valid drops", {63'd0, rsp_valid}, 64'd0);
    check("R1 ready back", {63'd0, req_ready}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_ctrl();
    t_warn();
    t_ids();
    t_enable();
    t_pend();
    t_private();
    t_prio();
    t_range();
    t_ones();
    t_raz();
    t_stall();
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule